// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment base and a 16-bit offset into a 20-bit physical memory address. It keeps four segment registers, for code, stack, data and extra data, which software loads through a write port. Each request names an access kind. The kind decides which segment register is used and which offset input goes with it: an instruction fetch pairs the code segment with the instruction pointer, a stack access pairs the stack segment with the stack pointer, and a data access pairs the data or extra segment with the index input.

A second mode runs the calculation in reverse. Given a physical address and the segment register chosen by the access kind, it returns the offset needed to reach that address. It raises an out-of-range flag when that offset cannot be held in 16 bits.

A small state machine controls the block. It has three states: `ST_IDLE`, with no response pending; `ST_FWD_RSP`, presenting a forward result; and `ST_INV_RSP`, presenting an inverse result. An accepted forward request moves the machine from any state to `ST_FWD_RSP`. An accepted inverse request moves it to `ST_INV_RSP`. Any cycle with no accepted request returns it to `ST_IDLE`. Both response states drive `rsp_valid` high. The block is fully pipelined: `req_ready` is high whenever reset is released, so a new request can be accepted in every cycle.

Top module: `seg_addr_gen`

## Requirements
- R1: While `rst_n` is low and after reset is released, `rsp_valid` is 0, `rsp_addr`, `rsp_offset` and `rsp_range_err` are 0, and all four segment registers hold 0000 hex.
- R2: `req_ready` is 1 whenever `rst_n` is high. A request with `req_valid` and `req_ready` both high is accepted on that clock edge. `rsp_valid` is 1 for exactly the cycle after each accepted request and is 0 after any edge that accepts no request.
- R3: In forward mode (`req_mode` = 0), `rsp_addr` equals segment × 16 + offset, taken modulo 2^20, so a carry out of bit 19 is lost. For example, segment 08F1 with offset 0100 gives 09010, and FFFF:FFFF gives 0FFEF. `rsp_offset` returns the offset that was used.
- R4: `req_kind` selects the operands. Code 0 (fetch) uses the code segment with `req_ip`. Code 1 (stack) uses the stack segment with `req_sp`. Code 2 (data) uses the data segment with `req_idx`. Code 3 (extra) uses the extra segment with `req_idx`. The inverse mode uses the same segment selection.
- R5: In inverse mode (`req_mode` = 1), `rsp_offset` equals `req_phys` − segment × 16 and `rsp_addr` echoes `req_phys`. For example, segment 002A with physical address 002C3 gives offset 0023.
- R6: In inverse mode, `rsp_range_err` is 1 when the difference is negative or above FFFF. In that case `rsp_offset` is 0000. In forward mode `rsp_range_err` is always 0.
- R7: When `seg_wr_en` is 1, the register addressed by `seg_wr_sel` (0 code, 1 stack, 2 data, 3 extra) takes `seg_wr_data` at the clock edge, and no other register changes. A request accepted on that same edge sees the old value, and requests accepted on later edges see the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Segment register load strobe |
| seg_wr_sel | input | 2 | Segment register to load (0 code, 1 stack, 2 data, 3 extra) |
| seg_wr_data | input | 16 | Value to load |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_mode | input | 1 | 0 forward, 1 inverse |
| req_kind | input | 2 | Access kind (0 fetch, 1 stack, 2 data, 3 extra) |
| req_ip | input | 16 | Instruction pointer offset |
| req_sp | input | 16 | Stack pointer offset |
| req_idx | input | 16 | Index offset for data and extra accesses |
| req_phys | input | 20 | Physical address for inverse mode |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_addr | output | 20 | Physical address (forward) or echoed address (inverse) |
| rsp_offset | output | 16 | Offset used (forward) or computed offset (inverse) |
| rsp_range_err | output | 1 | Inverse offset does not fit in 16 bits |

## Verification
The assertions check on every cycle that the response strobe appears only after an accepted request and lasts one cycle, that a raised range flag always comes with a zero offset, that a forward response never carries the flag, and that a segment register changes only when it is the target of a load and then takes the loaded value. The arithmetic can only be shown by the bench's sweeps, whose expected values come from integer arithmetic. These cover the wrap at 2^20, the borrow and overflow edges of the inverse mode, the pairing of each access kind with its segment and offset, and the same-edge load-and-request ordering.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
    localparam int NUM_SEG = 4;
    localparam int SEL_W   = $clog2(NUM_SEG);

    typedef enum logic [SEL_W-1:0] {
        ACC_FETCH = 2'd0,
        ACC_STACK = 2'd1,
        ACC_DATA  = 2'd2,
        ACC_EXTRA = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FWD_RSP = 2'd1,
        ST_INV_RSP = 2'd2
    } gen_state_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [SEG_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [SEG_W-1:0] rd_data
);
    logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (!rst_n)
                seg_q[g] <= '0;
            else if (wr_en && wr_sel == SEL_W'(g))
                seg_q[g] <= wr_data;
        end

        // R7: an untargeted register keeps its value
        a_r7_hold_untargeted: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_sel == SEL_W'(g)) |=> $stable(seg_q[g]));
    end

    assign rd_data = seg_q[rd_sel];

    // R7: a load lands in the addressed register
    a_r7_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> seg_q[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/seg_fwd_add.sv
module seg_fwd_add #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int PA_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  addr
);
    logic [PA_W-1:0] base_ext;
    logic [PA_W-1:0] off_ext;

    assign base_ext = {seg, {SHIFT{1'b0}}};
    assign off_ext  = {{(PA_W-OFF_W){1'b0}}, off};
    assign addr     = base_ext + off_ext;
endmodule

// File: rtl/seg_inv_sub.sv
module seg_inv_sub #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int PA_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [PA_W-1:0]  phys,
    output logic [OFF_W-1:0] off,
    output logic             range_err
);
    logic [PA_W:0] diff;
    logic          borrow;
    logic          too_big;

    assign diff      = {1'b0, phys} - {1'b0, seg, {SHIFT{1'b0}}};
    assign borrow    = diff[PA_W];
    assign too_big   = |diff[PA_W-1:OFF_W];
    assign range_err = borrow | too_big;
    assign off       = range_err ? '0 : diff[OFF_W-1:0];
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int PA_W = SEG_W + SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_wr_en,
    input  logic [1:0]       seg_wr_sel,
    input  logic [SEG_W-1:0] seg_wr_data,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_mode,
    input  logic [1:0]       req_kind,
    input  logic [OFF_W-1:0] req_ip,
    input  logic [OFF_W-1:0] req_sp,
    input  logic [OFF_W-1:0] req_idx,
    input  logic [PA_W-1:0]  req_phys,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_addr,
    output logic [OFF_W-1:0] rsp_offset,
    output logic             rsp_range_err
);
    gen_state_e       state_q, state_d;
    acc_kind_e        kind;
    logic             accept;
    logic [SEG_W-1:0] seg_val;
    logic [OFF_W-1:0] sel_off;
    logic [PA_W-1:0]  fwd_addr;
    logic [OFF_W-1:0] inv_off;
    logic             inv_err;
    logic [PA_W-1:0]  addr_q;
    logic [OFF_W-1:0] off_q;
    logic             err_q;

    assign kind      = acc_kind_e'(req_kind);
    assign req_ready = rst_n;
    assign accept    = req_valid && req_ready;

    seg_regfile #(.SEG_W(SEG_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_wr_sel),
        .wr_data (seg_wr_data),
        .rd_sel  (req_kind),
        .rd_data (seg_val)
    );

    always_comb begin
        unique case (kind)
            ACC_FETCH: sel_off = req_ip;
            ACC_STACK: sel_off = req_sp;
            ACC_DATA,
            ACC_EXTRA: sel_off = req_idx;
            default:   sel_off = req_idx;
        endcase
    end

    seg_fwd_add #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_fwd (
        .seg  (seg_val),
        .off  (sel_off),
        .addr (fwd_addr)
    );

    seg_inv_sub #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_inv (
        .seg       (seg_val),
        .phys      (req_phys),
        .off       (inv_off),
        .range_err (inv_err)
    );

    always_comb begin
        state_d = ST_IDLE;
        if (accept)
            state_d = req_mode ? ST_INV_RSP : ST_FWD_RSP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            off_q  <= '0;
            err_q  <= 1'b0;
        end else if (accept) begin
            addr_q <= req_mode ? req_phys : fwd_addr;
            off_q  <= req_mode ? inv_off  : sel_off;
            err_q  <= req_mode & inv_err;
        end
    end

    always_comb begin
        rsp_addr      = addr_q;
        rsp_offset    = off_q;
        rsp_range_err = err_q;
        unique case (state_q)
            ST_IDLE:    rsp_valid = 1'b0;
            ST_FWD_RSP,
            ST_INV_RSP: rsp_valid = 1'b1;
            default:    rsp_valid = 1'b0;
        endcase
    end

    // R1: reset clears the response
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && rsp_addr == '0 && rsp_offset == '0 && !rsp_range_err));

    // R2: a response strobe needs an accepted request on the previous edge
    a_r2_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready));

    // R2: no request means no response next cycle
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R6: a raised flag forces a zero offset
    a_r6_err_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_range_err |-> rsp_offset == '0);

    // R6: forward results never carry the flag
    a_r6_fwd_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FWD_RSP |-> !rsp_range_err);
endmodule

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = '0;
    logic [15:0] seg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_mode = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [15:0] req_ip = '0, req_sp = '0, req_idx = '0;
    logic [19:0] req_phys = '0;
    logic        rsp_valid;
    logic [19:0] rsp_addr;
    logic [15:0] rsp_offset;
    logic        rsp_range_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] model_seg [4];

    always #5 clk = ~clk;

    seg_addr_gen u_seg_addr_gen (
        .clk(clk), .rst_n(rst_n),
        .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
        .req_kind(req_kind), .req_ip(req_ip), .req_sp(req_sp), .req_idx(req_idx),
        .req_phys(req_phys), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_offset(rsp_offset), .rsp_range_err(rsp_range_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_seg(input int sel, input logic [15:0] val);
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_sel = 2'(sel); seg_wr_data = val;
        @(negedge clk);
        seg_wr_en = 1'b0;
        model_seg[sel] = val;
    endtask

    // drive one request, sample the response one edge later, check the pulse ends
    task automatic run_req(input logic mode, input int kind, input logic [15:0] ip,
                           input logic [15:0] sp, input logic [15:0] idx,
                           input logic [19:0] phys, input logic [15:0] seg_used);
        int off_i;
        int exp_addr;
        int diff;
        int exp_off;
        int exp_err;
        off_i = (kind == 0) ? int'(ip) : (kind == 1) ? int'(sp) : int'(idx);
        req_valid = 1'b1; req_mode = mode; req_kind = 2'(kind);
        req_ip = ip; req_sp = sp; req_idx = idx; req_phys = phys;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 rsp_valid after accept", 32'(rsp_valid), 32'd1);
        if (!mode) begin
            exp_addr = (int'(seg_used) * 16 + off_i) % 1048576;
            check("R3/R4 forward address", 32'(rsp_addr), 32'(exp_addr));
            check("R3/R4 forward offset", 32'(rsp_offset), 32'(off_i));
            check("R6 forward no flag", 32'(rsp_range_err), 32'd0);
        end else begin
            diff = int'(phys) - int'(seg_used) * 16;
            exp_err = (diff < 0 || diff > 65535) ? 1 : 0;
            exp_off = exp_err ? 0 : diff;
            check("R5 inverse echo", 32'(rsp_addr), 32'(phys));
            check("R5/R6 inverse offset", 32'(rsp_offset), 32'(exp_off));
            check("R6 inverse flag", 32'(rsp_range_err), 32'(exp_err));
        end
        @(negedge clk);
        check("R2 single-cycle pulse", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        logic [15:0] segs [5];
        logic [15:0] offs [5];
        segs = '{16'h0000, 16'h08F1, 16'hFFFF, 16'h002A, 16'hF001};
        offs = '{16'h0000, 16'h0100, 16'hFFFF, 16'h0023, 16'h8001};
        for (int i = 0; i < 4; i++) model_seg[i] = 16'h0000;

        repeat (3) @(negedge clk);
        // R1: held in reset
        check("R1 valid in reset", 32'(rsp_valid), 32'd0);
        check("R1 addr in reset", 32'(rsp_addr), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 ready after reset", 32'(req_ready), 32'd1);
        check("R1 valid after reset", 32'(rsp_valid), 32'd0);
        check("R1 offset after reset", 32'(rsp_offset), 32'd0);
        // R1: segment registers start at zero, visible through a forward request
        for (int k = 0; k < 4; k++)
            run_req(1'b0, k, 16'h1111, 16'h2222, 16'h3333, '0, 16'h0000);

        // R3 worked example and wrap
        load_seg(2, 16'h08F1);
        run_req(1'b0, 2, 16'h0, 16'h0, 16'h0100, '0, 16'h08F1);
        check("R3 example 09010", 32'(rsp_addr), 32'h09010);
        load_seg(2, 16'hFFFF);
        run_req(1'b0, 2, 16'h0, 16'h0, 16'hFFFF, '0, 16'hFFFF);
        check("R3 wrap 0FFEF", 32'(rsp_addr), 32'h0FFEF);

        // R4: distinct segments so a wrong pairing shows
        load_seg(0, 16'h1000);
        load_seg(1, 16'h2000);
        load_seg(2, 16'h3000);
        load_seg(3, 16'h4000);
        for (int k = 0; k < 4; k++)
            run_req(1'b0, k, 16'h0011, 16'h0022, 16'h0033, '0, model_seg[k]);

        // R3/R5/R6 sweep over every kind, segment, offset
        for (int s = 0; s < 5; s++) begin
            for (int k = 0; k < 4; k++) load_seg(k, segs[s] ^ 16'(k));
            for (int k = 0; k < 4; k++) begin
                for (int o = 0; o < 5; o++) begin
                    run_req(1'b0, k, offs[o], offs[o] ^ 16'h5A5A, offs[o] + 16'd1,
                            '0, model_seg[k]);
                    run_req(1'b1, k, '0, '0, '0,
                            20'({model_seg[k], 4'h0}) + 20'(offs[o]), model_seg[k]);
                end
                // R6 borrow and overflow edges
                run_req(1'b1, k, '0, '0, '0, 20'({model_seg[k], 4'h0}) - 20'd1, model_seg[k]);
                run_req(1'b1, k, '0, '0, '0, 20'({model_seg[k], 4'h0}) + 20'h10000, model_seg[k]);
                run_req(1'b1, k, '0, '0, '0, 20'hFFFFF, model_seg[k]);
                run_req(1'b1, k, '0, '0, '0, 20'h00000, model_seg[k]);
            end
        end

        // R5 worked example
        load_seg(3, 16'h002A);
        run_req(1'b1, 3, '0, '0, '0, 20'h002C3, 16'h002A);
        check("R5 example 0023", 32'(rsp_offset), 32'h0023);

        // R7: same-edge load and request uses the old value
        load_seg(2, 16'h0100);
        seg_wr_en = 1'b1; seg_wr_sel = 2'd2; seg_wr_data = 16'h0200;
        req_valid = 1'b1; req_mode = 1'b0; req_kind = 2'd2; req_idx = 16'h0005;
        @(negedge clk);
        seg_wr_en = 1'b0; req_valid = 1'b0;
        check("R7 same-edge old value", 32'(rsp_addr), 32'h01005);
        model_seg[2] = 16'h0200;
        @(negedge clk);
        run_req(1'b0, 2, '0, '0, 16'h0005, '0, 16'h0200);
        check("R7 new value next request", 32'(rsp_addr), 32'h02005);
        // R7: other registers untouched by that load
        run_req(1'b0, 3, '0, '0, 16'h0000, '0, 16'h002A);
        check("R7 extra segment unchanged", 32'(rsp_addr), 32'h002A0);

        // R2: back-to-back requests accepted every cycle
        @(negedge clk);
        req_valid = 1'b1; req_mode = 1'b0; req_kind = 2'd0; req_ip = 16'h0001;
        @(negedge clk);
        check("R2 back-to-back first", 32'(rsp_valid), 32'd1);
        req_ip = 16'h0002;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 back-to-back second", 32'(rsp_valid), 32'd1);
        check("R2 back-to-back addr", 32'(rsp_addr), 32'(20'({model_seg[0], 4'h0}) + 20'd2));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule